// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a cycle-accurate, synthesizable synchronous SRAM with a fixed two-cycle data phase. The rising clock edge captures the address, the controls and the byte write selects. The data for that command moves over a shared tristate bus in the following bus cycle. Because every command has the same pipeline depth, reads and writes can be issued on consecutive cycles in any order. The bus never needs an idle cycle to turn around.

A load/advance input chooses one of two actions. It can load a new external address, or it can step an internal two-bit beat counter. The counter yields four-beat bursts in linear or interleaved order from one starting address. Three chip selects gate new commands, and an active-low clock enable freezes the whole pipeline. An asynchronous output enable can release the bus at any time. The array is a small parameterized register file with byte lanes.

Top module: `pipe_sram`

## Requirements
- R1: A read command sampled at rising edge k drives the word at its address onto `dq` after edge k+1, so the word is valid at edge k+2. A write command sampled at edge k stores `dq` at edge k+2. The bus is not driven during a write's data phase.
- R2: Reads and writes may be issued on consecutive cycles in either order. A read issued the cycle after a write to the same address returns the newly written lanes.
- R3: While `cke_n` is high, all synchronous inputs are ignored. No pipeline register changes, no array write happens, and a pending data phase is held.
- R4: A new command starts only when `cs1_n`=0, `cs2`=1, `cs3_n`=0 and `adv`=0. Any other combination with `adv`=0 is a deselect, and the bus is high impedance in that cycle's data phase.
- R5: A deselect does not cancel reads or writes already issued, and their data phases still complete.
- R6: With `burst_ilv`=0 at load, beat n (n=0..3, n=0 being the load) uses low address bits (base+n) mod 4.
- R7: With `burst_ilv`=1 at load, beat n uses low address bits base XOR n.
- R8: An advance (`adv`=1) repeats the previous cycle's operation type on the next beat. An advance after a deselect is itself a deselect.
- R9: `bw_n[i]` is active low and is sampled with each command. It enables lane i, which is `dq[9i+8:9i]`. Disabled lanes keep their old contents.
- R10: While `oe_n` is high, `dq` is high impedance immediately, without waiting for a clock edge.
- R11: During and after reset no data phase is pending, and `dq` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| cke_n | input | 1 | Active-low clock enable; high stalls everything |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 = load new address, 1 = advance burst |
| rd_wrn | input | 1 | 1 = read, 0 = write (used on load) |
| bw_n | input | LANES | Active-low byte lane write selects |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq | inout | LANES*LANE_W | Tristate data bus |

## Verification
Each command's data phase is due two non-stalled rising edges after its command edge. The bench keeps a two-slot model of issued commands that shifts only on edges where `cke_n` is low. It drives write data or samples the bus for the command in the second slot. Samples are taken at the falling edge before the edge that completes the phase. The output enable settles one time step after it is applied, and the bench checks it in that same half cycle. A pullup on the bench side makes a released bus read as all ones. Write data is kept at zero in bit 35, so that value never occurs as real data.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // low two address bits of a burst beat
    function automatic logic [1:0] beat_lo(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction

endpackage

// File: rtl/psram_burst.sv
module psram_burst
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              adv,
    input  logic              cs_ok,
    input  logic              rd_wrn,
    input  logic              burst_ilv,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  bw_n_i,
    input  op_e               prev_op,
    input  logic [ADDR_W-3:0] prev_hi,
    input  logic [1:0]        prev_base,
    input  logic [1:0]        prev_cnt,
    input  logic              prev_ilv,
    output op_e               nxt_op,
    output logic [ADDR_W-3:0] nxt_hi,
    output logic [1:0]        nxt_base,
    output logic [1:0]        nxt_cnt,
    output logic              nxt_ilv,
    output logic [LANES-1:0]  nxt_bw_n
);

    always_comb begin
        nxt_op   = OP_IDLE;
        nxt_hi   = prev_hi;
        nxt_base = prev_base;
        nxt_cnt  = prev_cnt;
        nxt_ilv  = prev_ilv;
        nxt_bw_n = bw_n_i;
        if (adv) begin
            // continue previous operation; idle stays idle
            if (prev_op != OP_IDLE) begin
                nxt_op  = prev_op;
                nxt_cnt = prev_cnt + 2'd1;
            end
        end else if (cs_ok) begin
            nxt_op   = rd_wrn ? OP_READ : OP_WRITE;
            nxt_hi   = addr_i[ADDR_W-1:2];
            nxt_base = addr_i[1:0];
            nxt_cnt  = 2'd0;
            nxt_ilv  = burst_ilv;
        end
    end

endmodule

// File: rtl/psram_array.sv
module psram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic [LANES-1:0]         wmask,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [LANES*LANE_W-1:0]  rdata
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < LANES; i++) begin
                if (wmask[i]) begin
                    mem_q[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
                end
            end
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    adv,
    input  logic                    rd_wrn,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    burst_ilv,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    oe_n,
    inout  wire  [LANES*LANE_W-1:0] dq
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int HI_W   = ADDR_W - 2;

    typedef struct packed {
        op_e              op;
        logic [HI_W-1:0]  hi;
        logic [1:0]       base;
        logic [1:0]       cnt;
        logic             ilv;
        logic [LANES-1:0] bw_n;
    } cmd_t;

    typedef struct packed {
        op_e              op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0] bw_n;
    } phase_t;

    typedef struct packed {
        cmd_t              s1;
        phase_t            s2;
        logic [DATA_W-1:0] dout;
        logic              drive;
    } state_t;

    state_t st_d, st_q;

    logic              cs_ok;
    op_e               nb_op;
    logic [HI_W-1:0]   nb_hi;
    logic [1:0]        nb_base, nb_cnt;
    logic              nb_ilv;
    logic [LANES-1:0]  nb_bw_n;
    logic [ADDR_W-1:0] s1_addr;
    logic [DATA_W-1:0] rdata, fwd_data;
    logic              arr_we, fwd_hit;

    assign cs_ok   = !cs1_n && cs2 && !cs3_n;
    assign s1_addr = {st_q.s1.hi, beat_lo(st_q.s1.base, st_q.s1.cnt, st_q.s1.ilv)};

    psram_burst #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
        .adv       (adv),
        .cs_ok     (cs_ok),
        .rd_wrn    (rd_wrn),
        .burst_ilv (burst_ilv),
        .addr_i    (addr),
        .bw_n_i    (bw_n),
        .prev_op   (st_q.s1.op),
        .prev_hi   (st_q.s1.hi),
        .prev_base (st_q.s1.base),
        .prev_cnt  (st_q.s1.cnt),
        .prev_ilv  (st_q.s1.ilv),
        .nxt_op    (nb_op),
        .nxt_hi    (nb_hi),
        .nxt_base  (nb_base),
        .nxt_cnt   (nb_cnt),
        .nxt_ilv   (nb_ilv),
        .nxt_bw_n  (nb_bw_n)
    );

    // write commits during the data phase of the stage-2 command
    assign arr_we = !cke_n && (st_q.s2.op == OP_WRITE);

    psram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (st_q.s2.addr),
        .wdata (dq),
        .wmask (~st_q.s2.bw_n),
        .raddr (s1_addr),
        .rdata (rdata)
    );

    // a read right behind a write to the same word takes the bus lanes
    assign fwd_hit = (st_q.s2.op == OP_WRITE) && (st_q.s2.addr == s1_addr);

    for (genvar i = 0; i < LANES; i++) begin : g_fwd
        assign fwd_data[i*LANE_W +: LANE_W] =
            (fwd_hit && !st_q.s2.bw_n[i]) ? dq[i*LANE_W +: LANE_W]
                                          : rdata[i*LANE_W +: LANE_W];
    end

    always_comb begin
        st_d = st_q;
        if (!cke_n) begin
            st_d.s1.op   = nb_op;
            st_d.s1.hi   = nb_hi;
            st_d.s1.base = nb_base;
            st_d.s1.cnt  = nb_cnt;
            st_d.s1.ilv  = nb_ilv;
            st_d.s1.bw_n = nb_bw_n;
            st_d.s2.op   = st_q.s1.op;
            st_d.s2.addr = s1_addr;
            st_d.s2.bw_n = st_q.s1.bw_n;
            st_d.drive   = (st_q.s1.op == OP_READ);
            if (st_q.s1.op == OP_READ) begin
                st_d.dout = fwd_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq = (st_q.drive && !oe_n) ? st_q.dout : {DATA_W{1'bz}};

    // ---------------- assertions ----------------
    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(st_q.s1.op) && $stable(st_q.s2.op) && $stable(st_q.dout)
                   && $stable(st_q.drive)));

    assert_deselect_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv && !cs_ok) |=> (st_q.s1.op == OP_IDLE));

    assert_write_no_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s2.op == OP_WRITE) |-> !st_q.drive);

    assert_advance_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv && st_q.s1.op != OP_IDLE) |=>
            ((st_q.s1.cnt == $past(st_q.s1.cnt) + 2'd1) && (st_q.s1.op == $past(st_q.s1.op))));

    assert_issue_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n) |=> (st_q.s2.op == $past(st_q.s1.op)));

endmodule

// File: tb/test_pipe_sram.sv
`timescale 1ns/1ps
module test_pipe_sram;

    localparam int AW = 8;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam logic [DW-1:0] ALL1 = {DW{1'b1}};

    localparam logic [1:0] K_DS = 2'd0;
    localparam logic [1:0] K_RD = 2'd1;
    localparam logic [1:0] K_WR = 2'd2;
    localparam logic [1:0] K_AD = 2'd3;

    // {oe_n, cke_n, kind, ilv, bw_n, addr}
    localparam int NV = 38;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0,1'b0,K_RD,1'b0,4'h0,8'h10},  // R1 plain read
        {1'b0,1'b0,K_WR,1'b0,4'h0,8'h10},  // R2 read then write
        {1'b0,1'b0,K_RD,1'b0,4'h0,8'h10},  // R2 read right after write
        {1'b0,1'b0,K_WR,1'b0,4'b1010,8'h11}, // R9 lanes 0 and 2 only
        {1'b0,1'b0,K_RD,1'b0,4'h0,8'h11},  // R9 read merged word
        {1'b0,1'b0,K_DS,1'b0,4'h0,8'h00},  // R5 deselect via cs1_n
        {1'b0,1'b0,K_DS,1'b0,4'h0,8'h01},  // R4 deselect via cs2
        {1'b0,1'b0,K_RD,1'b0,4'h0,8'h22},  // R6 linear burst base 2
        {1'b0,1'b0,K_AD,1'b0,4'h0,8'h00},
        {1'b0,1'b0,K_AD,1'b0,4'h0,8'h00},
        {1'b0,1'b0,K_AD,1'b0,4'h0,8'h00},
        {1'b0,1'b0,K_RD,1'b1,4'h0,8'h25},  // R7 interleaved burst base 1
        {1'b0,1'b0,K_AD,1'b0,4'h0,8'h00},
        {1'b0,1'b0,K_AD,1'b0,4'h0,8'h00},
        {1'b0,1'b0,K_AD,1'b0,4'h0,8'h00},
        {1'b0,1'b0,K_WR,1'b1,4'h0,8'h32},  // R8 write burst, type carried
        {1'b0,1'b0,K_AD,1'b0,4'h0,8'h00},
        {1'b0,1'b0,K_AD,1'b0,4'b0110,8'h00},
        {1'b0,1'b0,K_RD,1'b0,4'h0,8'h33},
        {1'b0,1'b0,K_RD,1'b0,4'h0,8'h30},
        {1'b0,1'b0,K_RD,1'b0,4'h0,8'h32},
        {1'b0,1'b0,K_DS,1'b0,4'h0,8'h02},  // R4 deselect via cs3_n
        {1'b0,1'b0,K_AD,1'b0,4'h0,8'h00},  // R8 advance after deselect
        {1'b0,1'b0,K_RD,1'b0,4'h0,8'h40},
        {1'b0,1'b1,K_WR,1'b0,4'h0,8'h41},  // R3 stall, inputs ignored
        {1'b0,1'b1,K_WR,1'b0,4'h0,8'h40},  // R3
        {1'b0,1'b0,K_RD,1'b0,4'h0,8'h41},
        {1'b1,1'b0,K_WR,1'b0,4'h0,8'h42},  // R10 oe_n high in read phase
        {1'b0,1'b0,K_RD,1'b0,4'h0,8'h42},
        {1'b0,1'b0,K_WR,1'b0,4'h0,8'h50},
        {1'b0,1'b0,K_RD,1'b0,4'h0,8'h42},
        {1'b0,1'b1,K_RD,1'b0,4'h0,8'h51},  // R3 write phase held in stall
        {1'b0,1'b1,K_RD,1'b0,4'h0,8'h52},
        {1'b0,1'b0,K_RD,1'b0,4'h0,8'h50},
        {1'b0,1'b0,K_WR,1'b0,4'h0,8'h50},  // R2 alternating
        {1'b0,1'b0,K_RD,1'b0,4'h0,8'h50},
        {1'b0,1'b0,K_DS,1'b0,4'h0,8'h00},
        {1'b0,1'b0,K_DS,1'b0,4'h0,8'h00}
    };

    typedef struct {
        logic       v;
        logic       wr;
        logic [5:0] hi;
        logic [1:0] base;
        logic [1:0] cnt;
        logic       ilv;
        logic [3:0] bw_n;
    } mcmd_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cke_n, cs1_n, cs2, cs3_n, adv, rd_wrn, burst_ilv, oe_n;
    logic [NL-1:0] bw_n;
    logic [AW-1:0] addr;
    logic          tb_drv;
    logic [DW-1:0] tb_wdata;
    wire  [DW-1:0] dq;

    logic [DW-1:0] mem_model [256];
    mcmd_t         p1, p2;
    int            wcount;
    int            n_checks;
    int            n_fails;

    always #4 clk = ~clk;

    assign dq = tb_drv ? tb_wdata : {DW{1'bz}};

    for (genvar g = 0; g < DW; g++) begin : g_pu
        pullup pu (dq[g]);
    end

    pipe_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_pipe_sram (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke_n     (cke_n),
        .cs1_n     (cs1_n),
        .cs2       (cs2),
        .cs3_n     (cs3_n),
        .adv       (adv),
        .rd_wrn    (rd_wrn),
        .bw_n      (bw_n),
        .burst_ilv (burst_ilv),
        .addr      (addr),
        .oe_n      (oe_n),
        .dq        (dq)
    );

    function automatic logic [DW-1:0] wdata_f(input int n);
        logic [63:0] h;
        h = 64'(n) * 64'h9E37_79B1 ^ 64'h0A_5A5A_5A5A;
        return h[DW-1:0] & {1'b0, {(DW-1){1'b1}}};
    endfunction

    function automatic logic [AW-1:0] addr_of(input mcmd_t c);
        logic [1:0] lo;
        lo = c.ilv ? (c.base ^ c.cnt) : (c.base + c.cnt);
        return {c.hi, lo};
    endfunction

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                         input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: dq actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one bus cycle; called at a falling edge, returns at the next one
    task automatic step(input logic [16:0] v);
        logic [1:0] kind;
        mcmd_t      nc;
        kind      = v[14:13];
        oe_n      = v[16];
        cke_n     = v[15];
        burst_ilv = v[12];
        bw_n      = v[11:8];
        addr      = v[7:0];
        adv       = (kind == K_AD);
        rd_wrn    = (kind != K_WR);
        cs1_n     = 1'b0;
        cs2       = 1'b1;
        cs3_n     = 1'b0;
        if (kind == K_DS) begin
            case (v[1:0])
                2'd0:    cs1_n = 1'b1;
                2'd1:    cs2   = 1'b0;
                default: cs3_n = 1'b1;
            endcase
        end
        tb_drv   = p2.v && p2.wr;
        tb_wdata = wdata_f(wcount);
        #1;
        if (p2.v && !p2.wr && !oe_n) begin
            check(dq, mem_model[addr_of(p2)],
                  (p2.cnt == 2'd0) ? "R1" : (p2.ilv ? "R7" : "R6"));
        end else if (!(p2.v && p2.wr)) begin
            check(dq, ALL1, oe_n ? "R10" : "R4");
        end
        // next model command
        nc = p1;
        nc.bw_n = v[11:8];
        if (kind == K_AD) begin
            if (p1.v) nc.cnt = p1.cnt + 2'd1;
        end else if (kind == K_DS) begin
            nc.v = 1'b0;
        end else begin
            nc.v    = 1'b1;
            nc.wr   = (kind == K_WR);
            nc.hi   = v[7:2];
            nc.base = v[1:0];
            nc.cnt  = 2'd0;
            nc.ilv  = v[12];
        end
        @(posedge clk);
        if (!cke_n) begin
            if (p2.v && p2.wr) begin
                for (int i = 0; i < NL; i++) begin
                    if (!p2.bw_n[i])
                        mem_model[addr_of(p2)][i*LW +: LW] = tb_wdata[i*LW +: LW];
                end
                wcount++;
            end
            p2 = p1;
            p1 = nc;
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        n_checks = 0;
        n_fails  = 0;
        wcount   = 0;
        p1       = '{default: '0};
        p2       = '{default: '0};
        rst_n    = 1'b0;
        cke_n    = 1'b0;
        cs1_n    = 1'b1;
        cs2      = 1'b0;
        cs3_n    = 1'b1;
        adv      = 1'b0;
        rd_wrn   = 1'b1;
        bw_n     = '1;
        burst_ilv = 1'b0;
        addr     = '0;
        oe_n     = 1'b0;
        tb_drv   = 1'b0;
        tb_wdata = '0;
        repeat (3) @(negedge clk);
        check(dq, ALL1, "R11");  // bus released in reset
        rst_n = 1'b1;
        @(negedge clk);
        // fill every word with a full write (R1 write path)
        for (int i = 0; i < 256; i++) begin
            step({1'b0, 1'b0, K_WR, 1'b0, 4'h0, 8'(i)});
        end
        step({1'b0, 1'b0, K_DS, 1'b0, 4'h0, 8'h00});
        step({1'b0, 1'b0, K_DS, 1'b0, 4'h0, 8'h00});
        // vector table
        for (int k = 0; k < NV; k++) begin
            step(VEC[k]);
        end
        // directed: reset in mid-stream clears pending reads (R11)
        step({1'b0, 1'b0, K_RD, 1'b0, 4'h0, 8'h60});
        step({1'b0, 1'b0, K_RD, 1'b0, 4'h0, 8'h61});
        rst_n = 1'b0;
        p1 = '{default: '0};
        p2 = '{default: '0};
        cs1_n = 1'b1;
        #1;
        check(dq, ALL1, "R11");
        @(negedge clk);
        rst_n = 1'b1;
        step({1'b0, 1'b0, K_DS, 1'b0, 4'h0, 8'h00});
        step({1'b0, 1'b0, K_DS, 1'b0, 4'h0, 8'h00});
        // directed: wrapping linear and interleaved burst from base 3 (R6, R7)
        step({1'b0, 1'b0, K_RD, 1'b0, 4'h0, 8'h73});
        step({1'b0, 1'b0, K_AD, 1'b0, 4'h0, 8'h00});
        step({1'b0, 1'b0, K_AD, 1'b0, 4'h0, 8'h00});
        step({1'b0, 1'b0, K_RD, 1'b1, 4'h0, 8'h73});
        step({1'b0, 1'b0, K_AD, 1'b0, 4'h0, 8'h00});
        step({1'b0, 1'b0, K_AD, 1'b0, 4'h0, 8'h00});
        step({1'b0, 1'b0, K_AD, 1'b0, 4'h0, 8'h00});
        step({1'b0, 1'b0, K_DS, 1'b0, 4'h0, 8'h00});
        step({1'b0, 1'b0, K_DS, 1'b0, 4'h0, 8'h00});
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule